// File: doc/BRIEF.md
# Interrupt Message Aggregator

This block gathers eleven interrupt lines from devices behind a bus bridge and alerts one host processor by posting a single write transaction. The address and data of that write come from a programmable target word. Each input passes through a synchroniser. The block then looks for rising edges on the synchronised levels. An edge on a line that software has enabled latches a request bit and arms a message write. Only edges produce messages, not steady levels, so software that shares lines in level-triggered fashion must check the live level register after servicing and act again if a line is still high.

Software sees a small register slave. It holds the target word, an enable mask, a request register that clears on read, a pending register that also clears on read and records edges on every line whatever the mask, and a live level register. Reads return data in the same cycle that the select is presented. A read-clear takes effect at the clock edge that ends that cycle. The message port is a plain valid/ready write request.

Top module: `irq_msg_aggregator`

## Requirements
- R1: The level register at offset 0x028 shows the synchronised state of every input line, bit n for line n, whatever the mask. A change on an input appears there two clock edges after it is sampled.
- R2: A rising edge on line n sets request bit n (offset 0x00C) only when mask bit n (offset 0x018, bit n enables line n) is 1. Edges on lines whose mask bit is 0 leave the request register unchanged.
- R3: Only the bits selected by 0x5FF (lines 0 to 8 and line 10) can ever be set in the request register. An edge on line 9 sets no request bit and starts no message.
- R4: A read of the request register returns its contents and clears them. If a new enabled edge lands on a bit in the same cycle as that read, the bit is still set after the read.
- R5: The pending register at offset 0x01C latches rising edges on all eleven lines whatever the mask. Reading it returns its contents and clears it, and has no effect on the level register.
- R6: An enabled edge raises msg_valid. msg_addr carries the target word with its low five bits cleared, and msg_data carries those five bits zero-extended.
- R7: Once msg_valid is high, it stays high with msg_addr and msg_data unchanged until msg_ready is seen high at a clock edge.
- R8: Enabled edges that arrive while a message is outstanding merge into that message. A burst of such edges produces exactly one accepted write once msg_ready is given.
- R9: Setting a mask bit while that line is already high starts no message and sets no request bit.
- R10: After reset every register reads zero and msg_valid is low.
- R11: The target word at offset 0x004 reads back exactly as written. The mask reads back only its eleven low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 11 | Asynchronous interrupt lines, bit n is line n |
| reg_sel | input | 1 | Register access strobe for this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of a read |
| msg_valid | output | 1 | Message write request |
| msg_ready | input | 1 | Message write accepted at this edge |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
Two pairs of functions can meet in one cycle. A software read of the request register can hit the very edge at which a synchronised input edge sets a bit. The bench raises the line exactly two falling clock edges before it presents the read, so the clear and the set share one rising edge. It then expects the first read to show only the older bit and the second read to show the new one. The bench also holds msg_ready low while further enabled lines rise, so those edges merge into the outstanding message, and it counts accepted handshakes to confirm that exactly one write follows.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

   localparam logic [31:0] OFS_TARGET  = 32'h004;
   localparam logic [31:0] OFS_REQUEST = 32'h00C;
   localparam logic [31:0] OFS_MASK    = 32'h018;
   localparam logic [31:0] OFS_PENDING = 32'h01C;
   localparam logic [31:0] OFS_LEVEL   = 32'h028;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_TARGET,
      SEL_REQUEST,
      SEL_MASK,
      SEL_PENDING,
      SEL_LEVEL
   } reg_sel_e;

   function automatic reg_sel_e decode_reg(input logic [31:0] ofs);
      reg_sel_e s;
      case (ofs)
         OFS_TARGET:  s = SEL_TARGET;
         OFS_REQUEST: s = SEL_REQUEST;
         OFS_MASK:    s = SEL_MASK;
         OFS_PENDING: s = SEL_PENDING;
         OFS_LEVEL:   s = SEL_LEVEL;
         default:     s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
   parameter int unsigned NUM_LINES = 11,
   parameter int unsigned STAGES    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   output logic [NUM_LINES-1:0] level,
   output logic [NUM_LINES-1:0] rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irqagg_sync: STAGES must be at least 2");
   end
   if (NUM_LINES < 1) begin : g_bad_lines
      $error("irqagg_sync: NUM_LINES must be at least 1");
   end

   logic [NUM_LINES-1:0] prev_q;

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
         end else begin
            chain_q <= {chain_q[STAGES-2:0], irq_in[l]};
         end
      end
      assign level[l] = chain_q[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
      end else begin
         prev_q <= level;
      end
   end

   assign rise = level & ~prev_q;

endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
   import irqagg_pkg::*;
#(
   parameter int unsigned NUM_LINES = 11,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned IMPL_MASK = 'h5FF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_sel,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic [NUM_LINES-1:0] level,
   input  logic [NUM_LINES-1:0] rise,
   output logic [DATA_W-1:0]    target_q,
   output logic [NUM_LINES-1:0] mask_q,
   output logic [NUM_LINES-1:0] req_q,
   output logic [NUM_LINES-1:0] edge_hit,
   output logic                 req_read
);

   localparam logic [NUM_LINES-1:0] IMPL = NUM_LINES'(IMPL_MASK);

   if (NUM_LINES > DATA_W) begin : g_bad_width
      $error("irqagg_regs: NUM_LINES exceeds DATA_W");
   end
   if (ADDR_W > 32 || ADDR_W < 6) begin : g_bad_addr
      $error("irqagg_regs: ADDR_W must lie in 6..32");
   end

   reg_sel_e             rsel;
   logic                 rd_access;
   logic                 wr_access;
   logic                 pend_read;
   logic [NUM_LINES-1:0] pend_q;
   logic [NUM_LINES-1:0] req_d;
   logic [NUM_LINES-1:0] pend_d;

   assign rsel      = decode_reg(32'(reg_addr));
   assign rd_access = reg_sel & ~reg_wr;
   assign wr_access = reg_sel & reg_wr;
   assign req_read  = rd_access & (rsel == SEL_REQUEST);
   assign pend_read = rd_access & (rsel == SEL_PENDING);

   assign edge_hit = rise & mask_q & IMPL;

   always_comb begin
      req_d  = (req_read  ? '0 : req_q)  | edge_hit;
      pend_d = (pend_read ? '0 : pend_q) | rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         pend_q <= '0;
      end else begin
         req_q  <= req_d;
         pend_q <= pend_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         target_q <= '0;
         mask_q   <= '0;
      end else if (wr_access) begin
         if (rsel == SEL_TARGET) target_q <= reg_wdata;
         if (rsel == SEL_MASK)   mask_q   <= reg_wdata[NUM_LINES-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (rd_access) begin
         case (rsel)
            SEL_TARGET:  reg_rdata = target_q;
            SEL_REQUEST: reg_rdata = DATA_W'(req_q);
            SEL_MASK:    reg_rdata = DATA_W'(mask_q);
            SEL_PENDING: reg_rdata = DATA_W'(pend_q);
            SEL_LEVEL:   reg_rdata = DATA_W'(level);
            default:     reg_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/irqagg_msg.sv
module irqagg_msg #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned MSG_DATA_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trigger,
   input  logic [DATA_W-1:0] target,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [DATA_W-1:0] msg_addr,
   output logic [DATA_W-1:0] msg_data
);

   if (MSG_DATA_W < 1 || MSG_DATA_W >= DATA_W) begin : g_bad_split
      $error("irqagg_msg: MSG_DATA_W must lie in 1..DATA_W-1");
   end

   logic load;

   assign load = trigger & (~msg_valid | msg_ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
      end else if (trigger) begin
         msg_valid <= 1'b1;
      end else if (msg_ready) begin
         msg_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_addr <= '0;
         msg_data <= '0;
      end else if (load) begin
         msg_addr <= {target[DATA_W-1:MSG_DATA_W], {MSG_DATA_W{1'b0}}};
         msg_data <= DATA_W'(target[MSG_DATA_W-1:0]);
      end
   end

endmodule

// File: rtl/irq_msg_aggregator.sv
module irq_msg_aggregator #(
   parameter int unsigned NUM_LINES   = 11,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned MSG_DATA_W  = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned IMPL_MASK   = 'h5FF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 reg_sel,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic                 msg_valid,
   input  logic                 msg_ready,
   output logic [DATA_W-1:0]    msg_addr,
   output logic [DATA_W-1:0]    msg_data
);

   logic [NUM_LINES-1:0] level;
   logic [NUM_LINES-1:0] rise;
   logic [NUM_LINES-1:0] mask_q;
   logic [NUM_LINES-1:0] req_q;
   logic [NUM_LINES-1:0] edge_hit;
   logic [DATA_W-1:0]    target_q;
   logic                 req_read;

   irqagg_sync #(
      .NUM_LINES (NUM_LINES),
      .STAGES    (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq_in (irq_in),
      .level  (level),
      .rise   (rise)
   );

   irqagg_regs #(
      .NUM_LINES (NUM_LINES),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .IMPL_MASK (IMPL_MASK)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel   (reg_sel),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .level     (level),
      .rise      (rise),
      .target_q  (target_q),
      .mask_q    (mask_q),
      .req_q     (req_q),
      .edge_hit  (edge_hit),
      .req_read  (req_read)
   );

   irqagg_msg #(
      .DATA_W     (DATA_W),
      .MSG_DATA_W (MSG_DATA_W)
   ) u_msg (
      .clk       (clk),
      .rst_n     (rst_n),
      .trigger   (|edge_hit),
      .target    (target_q),
      .msg_valid (msg_valid),
      .msg_ready (msg_ready),
      .msg_addr  (msg_addr),
      .msg_data  (msg_data)
   );

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
   parameter int unsigned NUM_LINES = 11,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned IMPL_MASK = 'h5FF
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 msg_valid,
   input logic                 msg_ready,
   input logic [DATA_W-1:0]    msg_addr,
   input logic [DATA_W-1:0]    msg_data,
   input logic [NUM_LINES-1:0] edge_hit,
   input logic [NUM_LINES-1:0] mask_q,
   input logic [NUM_LINES-1:0] req_q,
   input logic                 req_read
);

   localparam logic [NUM_LINES-1:0] IMPL = NUM_LINES'(IMPL_MASK);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

   assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(msg_valid) |-> $past(msg_ready));

   assert_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_valid) |-> $past(|edge_hit));

   assert_impl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_q & ~IMPL) == '0));

   assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_read |=> ((req_q & $past(edge_hit)) == $past(edge_hit)));

   assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_read |=> (((req_q & ~$past(req_q)) & ~$past(mask_q)) == '0));

endmodule

bind irq_msg_aggregator irqagg_checker #(
   .NUM_LINES (NUM_LINES),
   .DATA_W    (DATA_W),
   .IMPL_MASK (IMPL_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .msg_valid (msg_valid),
   .msg_ready (msg_ready),
   .msg_addr  (msg_addr),
   .msg_data  (msg_data),
   .edge_hit  (edge_hit),
   .mask_q    (mask_q),
   .req_q     (req_q),
   .req_read  (req_read)
);

// File: tb/test_irq_msg_aggregator.sv
module test_irq_msg_aggregator;
   timeunit 1ns;
   timeprecision 100ps;

   localparam logic [11:0] A_TGT  = 12'h004;
   localparam logic [11:0] A_REQ  = 12'h00C;
   localparam logic [11:0] A_MSK  = 12'h018;
   localparam logic [11:0] A_PND  = 12'h01C;
   localparam logic [11:0] A_LVL  = 12'h028;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] irq_in = '0;
   logic        reg_sel = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        msg_valid;
   logic        msg_ready = 1'b0;
   logic [31:0] msg_addr;
   logic [31:0] msg_data;

   int n_chk = 0;
   int n_fail = 0;
   int n_msg = 0;

   always #2.5 clk = ~clk;

   irq_msg_aggregator i_irq_msg_aggregator (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .reg_sel   (reg_sel),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .msg_valid (msg_valid),
      .msg_ready (msg_ready),
      .msg_addr  (msg_addr),
      .msg_data  (msg_data)
   );

   always @(negedge clk) if (rst_n && msg_valid && msg_ready) n_msg++;

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_sel = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_TGT, v); check("R10 target", v, 0);
      rd(A_REQ, v); check("R10 request", v, 0);
      rd(A_MSK, v); check("R10 mask", v, 0);
      rd(A_PND, v); check("R10 pending", v, 0);
      rd(A_LVL, v); check("R10 level", v, 0);
      check("R10 msg_valid", 32'(msg_valid), 0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      wr(A_TGT, 32'hABCD_1234);
      rd(A_TGT, v); check("R11 target readback", v, 32'hABCD_1234);
      wr(A_MSK, 32'hFFFF_FFFF);
      rd(A_MSK, v); check("R11 mask width", v, 32'h7FF);
      wr(A_MSK, 0);
   endtask

   task automatic t_level();
      logic [31:0] v;
      int c0;
      c0 = n_msg;
      @(negedge clk); irq_in = 11'h00A;
      idle(4);
      rd(A_LVL, v); check("R1 level with mask clear", v, 32'h00A);
      rd(A_REQ, v); check("R2 masked edges no request", v, 0);
      rd(A_PND, v); check("R5 pending ignores mask", v, 32'h00A);
      rd(A_PND, v); check("R5 pending cleared by read", v, 0);
      rd(A_LVL, v); check("R5 level kept after pending read", v, 32'h00A);
      check("R2 no message from masked edges", 32'(n_msg - c0), 0);
   endtask

   task automatic t_message();
      logic [31:0] v;
      int c0;
      wr(A_MSK, 32'h001);
      @(negedge clk); irq_in = 11'h00B;
      idle(4);
      check("R6 msg_valid raised", 32'(msg_valid), 1);
      check("R6 msg_addr", msg_addr, 32'hABCD_1220);
      check("R6 msg_data", msg_data, 32'h14);
      idle(5);
      check("R7 held without ready", 32'(msg_valid), 1);
      wr(A_MSK, 32'h005);
      @(negedge clk); irq_in = 11'h00F;
      idle(4);
      check("R7 address stable while held", msg_addr, 32'hABCD_1220);
      c0 = n_msg;
      msg_ready = 1'b1;
      idle(8);
      check("R8 merged edges give one write", 32'(n_msg - c0), 1);
      check("R8 valid drops after accept", 32'(msg_valid), 0);
      rd(A_REQ, v); check("R2 request holds enabled edges", v, 32'h005);
      rd(A_REQ, v); check("R4 request cleared by read", v, 0);
   endtask

   task automatic t_unmask_high();
      logic [31:0] v;
      int c0;
      @(negedge clk); irq_in = '0;
      wr(A_MSK, 0);
      idle(4);
      @(negedge clk); irq_in = 11'h010;
      idle(5);
      c0 = n_msg;
      wr(A_MSK, 32'h010);
      idle(6);
      check("R9 no message on unmask of high line", 32'(n_msg - c0), 0);
      rd(A_REQ, v); check("R9 no request on unmask of high line", v, 0);
   endtask

   task automatic t_unimpl();
      logic [31:0] v;
      int c0;
      wr(A_MSK, 32'h7FF);
      c0 = n_msg;
      @(negedge clk); irq_in = 11'h210;
      idle(5);
      check("R3 line 9 starts no message", 32'(n_msg - c0), 0);
      rd(A_REQ, v); check("R3 line 9 sets no request", v, 0);
      @(negedge clk); irq_in = 11'h610;
      idle(5);
      check("R3 line 10 starts a message", 32'(n_msg - c0), 1);
      rd(A_REQ, v); check("R3 line 10 request bit", v, 32'h400);
   endtask

   task automatic t_read_collide();
      logic [31:0] v;
      logic [31:0] first;
      @(negedge clk); irq_in = 11'h612;
      idle(5);
      @(negedge clk); irq_in = 11'h632;
      @(negedge clk);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = A_REQ;
      #1 first = reg_rdata;
      @(negedge clk);
      reg_sel = 1'b0;
      check("R4 read before colliding edge", first, 32'h002);
      rd(A_REQ, v); check("R4 colliding edge survives read", v, 32'h020);
   endtask

   initial begin
      #(5.0 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      idle(4);
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      t_reset();
      t_regs();
      t_level();
      t_message();
      t_unmask_high();
      t_unimpl();
      t_read_collide();
      idle(4);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule